// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This unit sits beside one processor's cache controller on a snooping bus and gives that processor an atomic read-modify-write built from two operations. A load-linked returns the word supplied by the cache and records a reservation: a link flag and the block address of the access. A later store-conditional to the same block may write only while the link flag still holds. In that case it requests the bus and reports success once it is granted. In every other case it reports failure and leaves the bus and the other caches untouched. Software then retries from the load-linked.

Three kinds of event clear the reservation. The first is a write-type transaction from another agent that hits the reserved block: read-exclusive, upgrade or invalidate. The second is the local eviction of the reserved line. The third is the resolution of any store-conditional, whether it succeeds or fails. A new load-linked replaces whatever reservation was held. If a store-conditional is waiting for the bus and a competing writer to the block is snooped first, the unit withdraws its request and reports failure.

Top module: `llsc_reservation_unit`

## Requirements
- R1: A load-linked (op_is_sc=0) accepted while op_ready=1 produces, one cycle later, a single-cycle response with resp_valid=1, resp_is_sc=0 and resp_rdata equal to cache_rdata at acceptance. It also sets the link flag with the block address op_addr[ADDR_W-1:BLK_OFS].
- R2: A store-conditional (op_is_sc=1) whose block equals the reserved block, accepted while the link flag is set and nothing clears it that cycle, raises bus_req in the following cycle, with bus_addr=op_addr and bus_wdata=op_wdata. bus_req holds until bus_gnt. The cycle after the grant shows resp_valid=1, resp_is_sc=1, resp_ok=1 and bus_req=0.
- R3: A snoop with snoop_kind 1 (read-exclusive), 2 (upgrade) or 3 (invalidate) and snoop_blk equal to the reserved block clears the link flag. Kind 0 (shared read), or any snoop to another block, leaves the flag unchanged.
- R4: A store-conditional accepted while the link flag is clear, or while its block differs from the reserved block, fails. The cycle after acceptance shows resp_valid=1, resp_is_sc=1 and resp_ok=0, and bus_req never rises for it.
- R5: While a store-conditional waits for the bus, a conflicting snoop (as in R3) or a local eviction of the block, seen in a cycle without bus_gnt, withdraws the request. bus_req is 0 in the next cycle, and the response shows resp_ok=0. A bus_gnt in the same cycle as such a snoop wins, and the store-conditional succeeds.
- R6: Every store-conditional, whether it succeeds or fails, leaves the link flag clear, so a second store-conditional without a fresh load-linked fails.
- R7: evict_valid with evict_blk equal to the reserved block clears the link flag. An eviction of another block does not.
- R8: A new load-linked replaces the held reservation. After it, snoops to the old block do not affect the link, and a store-conditional to the old block fails.
- R9: While a store-conditional waits for the bus, op_ready=0 and offered operations are neither accepted nor answered.
- R10: During and right after reset, the link flag is clear, op_ready=1, bus_req=0 and resp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Processor offers an operation |
| op_is_sc | input | 1 | 0 = load-linked, 1 = store-conditional |
| op_addr | input | ADDR_W | Word address of the operation |
| op_wdata | input | DATA_W | Store-conditional data |
| cache_rdata | input | DATA_W | Word read from the local cache for a load-linked |
| op_ready | output | 1 | Unit accepts an operation this cycle |
| resp_valid | output | 1 | Single-cycle response strobe |
| resp_is_sc | output | 1 | Response belongs to a store-conditional |
| resp_ok | output | 1 | Store-conditional status: 1 success, 0 failure |
| resp_rdata | output | DATA_W | Load-linked return value |
| bus_req | output | 1 | Request for the bus to perform the store-conditional |
| bus_gnt | input | 1 | This processor won arbitration |
| bus_addr | output | ADDR_W | Address of the store-conditional write |
| bus_wdata | output | DATA_W | Data of the store-conditional write |
| snoop_valid | input | 1 | A transaction from another agent is on the bus |
| snoop_kind | input | 2 | 0 shared read, 1 read-exclusive, 2 upgrade, 3 invalidate |
| snoop_blk | input | ADDR_W-BLK_OFS | Block address of the snooped transaction |
| evict_valid | input | 1 | Local cache evicts a line |
| evict_blk | input | ADDR_W-BLK_OFS | Block address of the evicted line |

## Verification
The hardest case to reach is the lost race. A store-conditional must already hold a request on the bus while another agent's write to the same block is snooped before any grant, or in the same cycle as the grant. The stimulus reaches it by holding bus_gnt low after issue and injecting a read-exclusive snoop or a local eviction at a chosen negative edge. A grant and a snoop are also put in one cycle to show which takes priority. Reservation state that a port cannot show directly is observed through a following store-conditional and its grant.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

    typedef enum logic [1:0] {
        SNP_READ  = 2'd0,
        SNP_RDX   = 2'd1,
        SNP_UPGR  = 2'd2,
        SNP_INVAL = 2'd3
    } snoop_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic is_sc;
        logic ok;
    } resp_flags_t;

    function automatic logic snoop_is_write(input snoop_kind_e k);
        return k != SNP_READ;
    endfunction

endpackage

// File: rtl/llsc_blk_match.sv
`timescale 1ns/1ps
module llsc_blk_match
    import llsc_pkg::*;
#(
    parameter int unsigned TAG_W = 26
) (
    input  logic              link,
    input  logic [TAG_W-1:0]  resv_blk,
    input  logic              snoop_valid,
    input  snoop_kind_e       snoop_kind,
    input  logic [TAG_W-1:0]  snoop_blk,
    input  logic              evict_valid,
    input  logic [TAG_W-1:0]  evict_blk,
    input  logic [TAG_W-1:0]  op_blk,
    output logic              kill,
    output logic              sc_eligible
);
    logic snoop_conflict;
    logic evict_conflict;

    always_comb begin
        snoop_conflict = snoop_valid && snoop_is_write(snoop_kind) && (snoop_blk == resv_blk);
        evict_conflict = evict_valid && (evict_blk == resv_blk);
        kill           = link && (snoop_conflict || evict_conflict);
        // a reservation lost in the same cycle cannot back a new attempt
        sc_eligible    = link && !kill && (op_blk == resv_blk);
    end

endmodule

// File: rtl/llsc_resv_reg.sv
`timescale 1ns/1ps
module llsc_resv_reg #(
    parameter int unsigned TAG_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic [TAG_W-1:0]  set_blk,
    input  logic              clr,
    input  logic              kill,
    output logic              link,
    output logic [TAG_W-1:0]  blk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link <= 1'b0;
            blk  <= '0;
        end else if (set) begin
            link <= 1'b1;
            blk  <= set_blk;
        end else if (clr || kill) begin
            link <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_sc_seq.sv
`timescale 1ns/1ps
module llsc_sc_seq
    import llsc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ll_fire,
    input  logic               sc_fire,
    input  logic               sc_eligible,
    input  logic               kill,
    input  logic               bus_gnt,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [DATA_W-1:0]  op_wdata,
    input  logic [DATA_W-1:0]  cache_rdata,
    output logic               op_ready,
    output logic               bus_req,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output resp_flags_t        resp,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               link_clr
);
    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        op_ready  = (state_q == SEQ_IDLE);
        bus_req   = (state_q == SEQ_WAIT);
        bus_addr  = addr_q;
        bus_wdata = data_q;
        link_clr  = (sc_fire && !sc_eligible) || (bus_req && bus_gnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            addr_q     <= '0;
            data_q     <= '0;
            resp       <= '0;
            resp_rdata <= '0;
        end else begin
            resp <= '0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (ll_fire) begin
                        resp       <= '{valid: 1'b1, is_sc: 1'b0, ok: 1'b0};
                        resp_rdata <= cache_rdata;
                    end else if (sc_fire) begin
                        if (sc_eligible) begin
                            state_q <= SEQ_WAIT;
                            addr_q  <= op_addr;
                            data_q  <= op_wdata;
                        end else begin
                            resp <= '{valid: 1'b1, is_sc: 1'b1, ok: 1'b0};
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (bus_gnt) begin
                        state_q <= SEQ_IDLE;
                        resp    <= '{valid: 1'b1, is_sc: 1'b1, ok: 1'b1};
                    end else if (kill) begin
                        state_q <= SEQ_IDLE;
                        resp    <= '{valid: 1'b1, is_sc: 1'b1, ok: 1'b0};
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/llsc_reservation_unit.sv
`timescale 1ns/1ps
module llsc_reservation_unit
    import llsc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BLK_OFS = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      op_valid,
    input  logic                      op_is_sc,
    input  logic [ADDR_W-1:0]         op_addr,
    input  logic [DATA_W-1:0]         op_wdata,
    input  logic [DATA_W-1:0]         cache_rdata,
    output logic                      op_ready,
    output logic                      resp_valid,
    output logic                      resp_is_sc,
    output logic                      resp_ok,
    output logic [DATA_W-1:0]         resp_rdata,
    output logic                      bus_req,
    input  logic                      bus_gnt,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_wdata,
    input  logic                      snoop_valid,
    input  logic [1:0]                snoop_kind,
    input  logic [ADDR_W-BLK_OFS-1:0] snoop_blk,
    input  logic                      evict_valid,
    input  logic [ADDR_W-BLK_OFS-1:0] evict_blk
);
    localparam int unsigned TAG_W = ADDR_W - BLK_OFS;

    logic              accept, ll_fire, sc_fire;
    logic              link_q, link_clr, kill, sc_eligible;
    logic [TAG_W-1:0]  resv_blk_q;
    resp_flags_t       resp;

    always_comb begin
        accept  = op_valid && op_ready;
        ll_fire = accept && !op_is_sc;
        sc_fire = accept && op_is_sc;
    end

    llsc_blk_match #(.TAG_W(TAG_W)) u_match (
        .link        (link_q),
        .resv_blk    (resv_blk_q),
        .snoop_valid (snoop_valid),
        .snoop_kind  (snoop_kind_e'(snoop_kind)),
        .snoop_blk   (snoop_blk),
        .evict_valid (evict_valid),
        .evict_blk   (evict_blk),
        .op_blk      (op_addr[ADDR_W-1:BLK_OFS]),
        .kill        (kill),
        .sc_eligible (sc_eligible)
    );

    llsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk     (clk),
        .rst     (rst),
        .set     (ll_fire),
        .set_blk (op_addr[ADDR_W-1:BLK_OFS]),
        .clr     (link_clr),
        .kill    (kill),
        .link    (link_q),
        .blk     (resv_blk_q)
    );

    llsc_sc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ll_fire     (ll_fire),
        .sc_fire     (sc_fire),
        .sc_eligible (sc_eligible),
        .kill        (kill),
        .bus_gnt     (bus_gnt),
        .op_addr     (op_addr),
        .op_wdata    (op_wdata),
        .cache_rdata (cache_rdata),
        .op_ready    (op_ready),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .resp        (resp),
        .resp_rdata  (resp_rdata),
        .link_clr    (link_clr)
    );

    always_comb begin
        resp_valid = resp.valid;
        resp_is_sc = resp.is_sc;
        resp_ok    = resp.ok;
    end

endmodule

// File: rtl/llsc_reservation_checker.sv
`timescale 1ns/1ps
module llsc_reservation_checker #(
    parameter int unsigned TAG_W = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_is_sc,
    input logic             op_ready,
    input logic             resp_valid,
    input logic             resp_is_sc,
    input logic             resp_ok,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             snoop_valid,
    input logic [1:0]       snoop_kind,
    input logic [TAG_W-1:0] snoop_blk,
    input logic             evict_valid,
    input logic [TAG_W-1:0] evict_blk,
    input logic             link,
    input logic [TAG_W-1:0] resv_blk
);
    a_r2_req_needs_link: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> link);

    a_r2_grant_succeeds: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> (resp_valid && resp_is_sc && resp_ok && !bus_req));

    a_r4_dead_link_no_bus: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_is_sc && !link) |=> (!bus_req && resp_valid && !resp_ok));

    a_r3_write_snoop_clears: assert property (@(posedge clk) disable iff (rst)
        (link && snoop_valid && snoop_kind != 2'd0 && snoop_blk == resv_blk
         && !(op_valid && op_ready && !op_is_sc)) |=> !link);

    a_r7_evict_clears: assert property (@(posedge clk) disable iff (rst)
        (link && evict_valid && evict_blk == resv_blk
         && !(op_valid && op_ready && !op_is_sc)) |=> !link);

    a_r5_lost_race: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && link && snoop_valid && snoop_kind != 2'd0
         && snoop_blk == resv_blk) |=> (!bus_req && resp_valid && !resp_ok));

    a_r6_sc_result_clears: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_is_sc) |-> !link);

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !op_ready);

    a_r2_ok_only_sc: assert property (@(posedge clk) disable iff (rst)
        resp_ok |-> (resp_valid && resp_is_sc));

endmodule

bind llsc_reservation_unit llsc_reservation_checker #(.TAG_W(ADDR_W - BLK_OFS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_is_sc    (op_is_sc),
    .op_ready    (op_ready),
    .resp_valid  (resp_valid),
    .resp_is_sc  (resp_is_sc),
    .resp_ok     (resp_ok),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .snoop_valid (snoop_valid),
    .snoop_kind  (snoop_kind),
    .snoop_blk   (snoop_blk),
    .evict_valid (evict_valid),
    .evict_blk   (evict_blk),
    .link        (link_q),
    .resv_blk    (resv_blk_q)
);

// File: tb/llsc_reservation_unit_test.sv
`timescale 1ns/1ps
module llsc_reservation_unit_test;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BLK_OFS = 6;
    localparam int unsigned TAG_W = ADDR_W - BLK_OFS;

    localparam logic [31:0] ADR_A  = 32'h0000_1040;
    localparam logic [31:0] ADR_A2 = 32'h0000_1044;
    localparam logic [31:0] ADR_B  = 32'h0000_2080;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0, op_is_sc = 1'b0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [DATA_W-1:0] op_wdata = '0, cache_rdata = '0;
    logic op_ready, resp_valid, resp_is_sc, resp_ok, bus_req;
    logic [DATA_W-1:0] resp_rdata, bus_wdata;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_gnt = 1'b0, snoop_valid = 1'b0, evict_valid = 1'b0;
    logic [1:0] snoop_kind = 2'd0;
    logic [TAG_W-1:0] snoop_blk = '0, evict_blk = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    llsc_reservation_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_OFS(BLK_OFS)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_is_sc(op_is_sc),
        .op_addr(op_addr), .op_wdata(op_wdata), .cache_rdata(cache_rdata),
        .op_ready(op_ready), .resp_valid(resp_valid), .resp_is_sc(resp_is_sc),
        .resp_ok(resp_ok), .resp_rdata(resp_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .snoop_valid(snoop_valid), .snoop_kind(snoop_kind), .snoop_blk(snoop_blk),
        .evict_valid(evict_valid), .evict_blk(evict_blk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] blk_of(input logic [31:0] a);
        return a[ADDR_W-1:BLK_OFS];
    endfunction

    task automatic do_ll(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); op_valid = 1'b1; op_is_sc = 1'b0; op_addr = a; cache_rdata = d;
        @(posedge clk); #1;
        chk("R1 ll resp_valid", {31'd0, resp_valid}, 32'd1);
        chk("R1 ll resp_is_sc", {31'd0, resp_is_sc}, 32'd0);
        chk("R1 ll rdata", resp_rdata, d);
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic sc_offer(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); op_valid = 1'b1; op_is_sc = 1'b1; op_addr = a; op_wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic sc_expect_fail(input logic [31:0] a, input string tag);
        sc_offer(a, 32'hDEAD_0000);
        chk({tag, " fail resp_valid"}, {31'd0, resp_valid}, 32'd1);
        chk({tag, " fail resp_is_sc"}, {31'd0, resp_is_sc}, 32'd1);
        chk({tag, " fail resp_ok"}, {31'd0, resp_ok}, 32'd0);
        chk({tag, " fail no bus_req"}, {31'd0, bus_req}, 32'd0);
        @(negedge clk); op_valid = 1'b0;
        chk({tag, " fail bus_req stays low"}, {31'd0, bus_req}, 32'd0);
    endtask

    task automatic sc_expect_wait(input logic [31:0] a, input logic [31:0] d, input string tag);
        sc_offer(a, d);
        chk({tag, " bus_req"}, {31'd0, bus_req}, 32'd1);
        chk({tag, " bus_addr"}, bus_addr, a);
        chk({tag, " bus_wdata"}, bus_wdata, d);
        chk({tag, " no early resp"}, {31'd0, resp_valid}, 32'd0);
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic grant_expect_ok(input string tag);
        @(negedge clk); bus_gnt = 1'b1;
        @(posedge clk); #1;
        chk({tag, " ok resp_valid"}, {31'd0, resp_valid}, 32'd1);
        chk({tag, " ok resp_ok"}, {31'd0, resp_ok}, 32'd1);
        chk({tag, " ok bus_req dropped"}, {31'd0, bus_req}, 32'd0);
        @(negedge clk); bus_gnt = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] k, input logic [31:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_kind = k; snoop_blk = blk_of(a);
        @(posedge clk); #1;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic evict(input logic [31:0] a);
        @(negedge clk); evict_valid = 1'b1; evict_blk = blk_of(a);
        @(posedge clk); #1;
        @(negedge clk); evict_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 op_ready", {31'd0, op_ready}, 32'd1);
        chk("R10 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R10 resp_valid", {31'd0, resp_valid}, 32'd0);
        sc_expect_fail(ADR_A, "R10 link clear after reset");
    endtask

    task automatic t_basic;
        do_ll(ADR_A, 32'h1234_5678);
        sc_expect_wait(ADR_A2, 32'hCAFE_0001, "R2");
        repeat (2) @(posedge clk);
        #1 chk("R2 bus_req held", {31'd0, bus_req}, 32'd1);
        chk("R9 op_ready low while waiting", {31'd0, op_ready}, 32'd0);
        @(negedge clk); op_valid = 1'b1; op_is_sc = 1'b0; op_addr = ADR_B; cache_rdata = 32'h5555;
        @(posedge clk); #1;
        chk("R9 offered op not answered", {31'd0, resp_valid}, 32'd0);
        @(negedge clk); op_valid = 1'b0;
        grant_expect_ok("R2");
        sc_expect_fail(ADR_A, "R6 after success");
        sc_expect_fail(ADR_B, "R9 ignored ll left no reservation");
    endtask

    task automatic t_snoops;
        do_ll(ADR_A, 32'h1);
        snoop(2'd0, ADR_A);
        snoop(2'd1, ADR_B);
        sc_expect_wait(ADR_A, 32'h2, "R3 read/other-block snoop kept link");
        grant_expect_ok("R3 read/other-block snoop kept link");
        do_ll(ADR_A, 32'h3);
        snoop(2'd2, ADR_A2);
        sc_expect_fail(ADR_A, "R3 upgrade snoop");
        do_ll(ADR_A, 32'h4);
        snoop(2'd3, ADR_A);
        sc_expect_fail(ADR_A, "R3 invalidate snoop");
        do_ll(ADR_A, 32'h5);
        snoop(2'd1, ADR_A);
        sc_expect_fail(ADR_A, "R3 read-exclusive snoop");
    endtask

    task automatic t_mismatch;
        do_ll(ADR_A, 32'h6);
        sc_expect_fail(ADR_B, "R4 block mismatch");
        sc_expect_fail(ADR_A, "R6 after failure");
    endtask

    task automatic t_lost_race;
        do_ll(ADR_A, 32'h7);
        sc_expect_wait(ADR_A, 32'h8, "R5 race");
        @(negedge clk); snoop_valid = 1'b1; snoop_kind = 2'd1; snoop_blk = blk_of(ADR_A);
        @(posedge clk); #1;
        chk("R5 lost race bus_req dropped", {31'd0, bus_req}, 32'd0);
        chk("R5 lost race resp_valid", {31'd0, resp_valid}, 32'd1);
        chk("R5 lost race resp_ok", {31'd0, resp_ok}, 32'd0);
        @(negedge clk); snoop_valid = 1'b0;
        do_ll(ADR_A, 32'h9);
        sc_expect_wait(ADR_A, 32'hA, "R5 evict while waiting");
        @(negedge clk); evict_valid = 1'b1; evict_blk = blk_of(ADR_A);
        @(posedge clk); #1;
        chk("R5 evict while waiting bus_req", {31'd0, bus_req}, 32'd0);
        chk("R5 evict while waiting resp_ok", {31'd0, resp_ok}, 32'd0);
        chk("R5 evict while waiting resp_valid", {31'd0, resp_valid}, 32'd1);
        @(negedge clk); evict_valid = 1'b0;
        do_ll(ADR_A, 32'hB);
        sc_expect_wait(ADR_A, 32'hC, "R5 grant vs snoop");
        @(negedge clk); bus_gnt = 1'b1; snoop_valid = 1'b1; snoop_kind = 2'd1; snoop_blk = blk_of(ADR_A);
        @(posedge clk); #1;
        chk("R5 grant wins resp_ok", {31'd0, resp_ok}, 32'd1);
        chk("R5 grant wins resp_valid", {31'd0, resp_valid}, 32'd1);
        @(negedge clk); bus_gnt = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic t_evict;
        do_ll(ADR_A, 32'hD);
        evict(ADR_B);
        sc_expect_wait(ADR_A, 32'hE, "R7 other-block eviction kept link");
        grant_expect_ok("R7 other-block eviction kept link");
        do_ll(ADR_A, 32'hF);
        evict(ADR_A);
        sc_expect_fail(ADR_A, "R7 reserved-block eviction");
    endtask

    task automatic t_overwrite;
        do_ll(ADR_A, 32'h10);
        do_ll(ADR_B, 32'h11);
        snoop(2'd1, ADR_A);
        evict(ADR_A);
        sc_expect_wait(ADR_B, 32'h12, "R8 new reservation survives old-block writes");
        grant_expect_ok("R8 new reservation survives old-block writes");
        do_ll(ADR_A, 32'h13);
        do_ll(ADR_B, 32'h14);
        sc_expect_fail(ADR_A, "R8 old block no longer reserved");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R10 op_ready in reset", {31'd0, op_ready}, 32'd1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_snoops();
        t_mismatch();
        t_lost_race();
        t_evict();
        t_overwrite();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule